// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and replacement state of an n-way set-associative cache and answers one lookup per clock. Each request address is cut into three fields: the low bits select a word within a block, the next bits pick the set, and the remaining high bits form the tag. All ways of the chosen set are compared at once. A match counts only when that line is valid. The result comes back on the clock edge after the request: hit or miss, the matching way, the replacement candidate, and a one-word data array entry for the hit line.

Replacement is least-recently-used. Each line holds a copy of a free-running access counter. The copy is written when the line is filled or hit, and on a miss the line with the oldest copy is chosen. Empty lines are always chosen before any valid line. When the caller asks for a fill on a miss, the chosen line is loaded with the new tag and data in the same cycle. Setting the number of sets to one makes the cache fully associative, and every line is then compared.

Top module: `cache_tag_ctrl`

## Requirements
- R1: With the default geometry (16-bit address, 2 offset bits, 4 sets), bits [1:0] are the word offset, bits [3:2] select the set (the block number modulo the set count), and bits [15:4] are the tag. The same tag in a different set is a different line.
- R2: Reset clears every valid bit and the response outputs. Any lookup after reset misses, including a lookup of a line that was filled before the reset.
- R3: A hit is reported only when a way of the selected set is valid and holds the request tag. The offset bits take no part in the match.
- R4: `rsp_valid` is high in exactly the cycle after a request is taken, and low after an idle cycle.
- R5: On a hit, `rsp_hit` is 1, `rsp_way` gives the matching way and `rsp_data` gives that line's stored word. On a miss, `rsp_way` and `rsp_data` are 0.
- R6: A miss with `req_fill` set writes the tag, the valid bit, the current stamp and `req_wdata` into the way reported on `rsp_victim`. A later lookup of that address hits in that way.
- R7: A miss without `req_fill` changes no line. Repeating the lookup misses again and reports the same victim.
- R8: If the selected set has an invalid way, the victim is the lowest-numbered invalid way.
- R9: If all ways are valid, the victim is the way with the smallest stamp, with ties going to the lowest way. The stamp counter advances on every accepted request, and a hit restamps the hit line.
- R10: A hit with `req_fill` set does not rewrite the line. The stored word stays as it was.
- R11: With one set, the index field disappears, the tag is bits [15:2], and any line can hold any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the lookup |
| req_fill | input | 1 | Allocate on a miss |
| req_wdata | input | DATA_W | Word stored on a fill |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Matching way on a hit, else 0 |
| rsp_victim | output | WAY_W | Replacement candidate in the selected set |
| rsp_data | output | DATA_W | Stored word of the hit line, else 0 |

## Verification
Choosing a victim and filling it happen in the same cycle as the lookup. Likewise, reporting a hit and restamping that line share one edge. The bench fills a full set on a miss and then, on back-to-back requests, looks up both the new address and the address it displaced. It checks that the first hits in the reported victim way and the second misses. It also checks that the very next victim report reflects the fresh stamps, which shows that the stamp written on a hit changed the following replacement choice.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    // Width needed to number n items, never less than one bit.
    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 12,
    parameter int unsigned WAY_W = cache_tag_pkg::bits_for(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);

    // One comparator per way, all in parallel.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
    end

    assign any_hit = |hit_vec;

    // Encode the matching way; the lowest index wins if ever several match.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TS_W  = 16,
    parameter int unsigned WAY_W = cache_tag_pkg::bits_for(WAYS)
) (
    input  logic [WAYS-1:0]           way_valid,
    input  logic [WAYS-1:0][TS_W-1:0] way_ts,
    output logic [WAY_W-1:0]          victim
);

    logic            empty_found;
    logic [TS_W-1:0] oldest;

    always_comb begin
        empty_found = 1'b0;
        victim      = '0;
        oldest      = way_ts[0];
        // An empty way beats every valid one; the lowest empty way is taken.
        for (int w = 0; w < WAYS; w++) begin
            if (!empty_found && !way_valid[w]) begin
                empty_found = 1'b1;
                victim      = WAY_W'(w);
            end
        end
        // Otherwise the oldest stamp; a strict compare keeps ties low.
        if (!empty_found) begin
            for (int w = 1; w < WAYS; w++) begin
                if (way_ts[w] < oldest) begin
                    oldest = way_ts[w];
                    victim = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned OFFSET_W = 2,
    parameter int unsigned SETS     = 4,
    parameter int unsigned WAYS     = 2,
    parameter int unsigned TS_W     = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned WAY_W    = cache_tag_pkg::bits_for(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fill,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [WAY_W-1:0]  rsp_victim,
    output logic [DATA_W-1:0] rsp_data
);

    localparam int unsigned IDX_W  = (SETS > 1) ? $clog2(SETS) : 0;
    localparam int unsigned IDX_SZ = cache_tag_pkg::bits_for(SETS);
    localparam int unsigned TAG_W  = ADDR_W - OFFSET_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TS_W-1:0]   ts;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data;
        logic [TS_W-1:0]                       now;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic [WAY_W-1:0]                      rsp_way;
        logic [WAY_W-1:0]                      rsp_victim;
        logic [DATA_W-1:0]                     rsp_data;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    // Address fields.
    logic [IDX_SZ-1:0] set_idx;
    logic [TAG_W-1:0]  probe_tag;
    logic [OFFSET_W-1:0] unused_offset;

    assign probe_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = req_addr[OFFSET_W-1:0];

    if (SETS > 1) begin : g_indexed
        assign set_idx = req_addr[OFFSET_W +: IDX_SZ];
    end else begin : g_full_assoc
        assign set_idx = '0;
    end

    // Selected set.
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0][TS_W-1:0]   set_ts;
    logic [WAYS-1:0][DATA_W-1:0] set_data;

    assign set_tag   = state_q.tag[set_idx];
    assign set_valid = state_q.valid[set_idx];
    assign set_ts    = state_q.ts[set_idx];
    assign set_data  = state_q.data[set_idx];

    logic [WAYS-1:0]  hit_vec;
    logic             any_hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;

    cache_tag_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .WAY_W (WAY_W)
    ) u_match (
        .way_tag   (set_tag),
        .way_valid (set_valid),
        .probe_tag (probe_tag),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .hit_way   (hit_way)
    );

    cache_victim_pick #(
        .WAYS  (WAYS),
        .TS_W  (TS_W),
        .WAY_W (WAY_W)
    ) u_victim (
        .way_valid (set_valid),
        .way_ts    (set_ts),
        .victim    (victim)
    );

    // Next-state logic.
    always_comb begin
        state_d            = state_q;
        state_d.rsp_valid  = req_valid;
        state_d.rsp_hit    = 1'b0;
        state_d.rsp_way    = '0;
        state_d.rsp_victim = '0;
        state_d.rsp_data   = '0;
        if (req_valid) begin
            state_d.now        = state_q.now + TS_W'(1);
            state_d.rsp_hit    = any_hit;
            state_d.rsp_victim = victim;
            if (any_hit) begin
                state_d.rsp_way                   = hit_way;
                state_d.rsp_data                  = set_data[hit_way];
                state_d.ts[set_idx][hit_way]      = state_q.now;
            end else if (req_fill) begin
                state_d.tag[set_idx][victim]   = probe_tag;
                state_d.valid[set_idx][victim] = 1'b1;
                state_d.ts[set_idx][victim]    = state_q.now;
                state_d.data[set_idx][victim]  = req_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid  = state_q.rsp_valid;
    assign rsp_hit    = state_q.rsp_hit;
    assign rsp_way    = state_q.rsp_way;
    assign rsp_victim = state_q.rsp_victim;
    assign rsp_data   = state_q.rsp_data;

    // Checks.
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(hit_vec));

    p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fill && !any_hit) |=>
            (state_q.valid[$past(set_idx)][$past(victim)] &&
             state_q.tag[$past(set_idx)][$past(victim)] == $past(probe_tag)));

    p_miss_keeps_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fill && !any_hit) |=>
            ($stable(state_q.valid) && $stable(state_q.tag) && $stable(state_q.data)));

    p_empty_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(&set_valid)) |-> !set_valid[victim]);

    p_stamp_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (state_q.now == TS_W'($past(state_q.now) + TS_W'(1))));

    p_hit_no_rewrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hit) |=>
            ($stable(state_q.valid) && $stable(state_q.tag) && $stable(state_q.data)));

endmodule

// File: tb/cache_tag_ctrl_test.sv
module cache_tag_ctrl_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr  = '0;
    logic        req_fill  = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid, rsp_hit;
    logic [0:0]  rsp_way, rsp_victim;
    logic [7:0]  rsp_data;

    logic        fa_valid = 1'b0;
    logic [15:0] fa_addr  = '0;
    logic        fa_fill  = 1'b0;
    logic [7:0]  fa_wdata = '0;
    logic        fa_rvalid, fa_hit;
    logic [1:0]  fa_way, fa_victim;
    logic [7:0]  fa_data;

    cache_tag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_fill(req_fill), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
        .rsp_data(rsp_data)
    );

    cache_tag_ctrl #(.SETS(1), .WAYS(4)) uut_fa (
        .clk(clk), .rst_n(rst_n), .req_valid(fa_valid), .req_addr(fa_addr),
        .req_fill(fa_fill), .req_wdata(fa_wdata), .rsp_valid(fa_rvalid),
        .rsp_hit(fa_hit), .rsp_way(fa_way), .rsp_victim(fa_victim),
        .rsp_data(fa_data)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        fill;
        logic [7:0]  wd;
        logic        hit;
        logic [0:0]  way;
        logic [0:0]  vic;
        logic [7:0]  data;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0104, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd8},  // R8 empty set, way0 taken
        '{16'h0104, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA1, 4'd6},  // R6 filled line hits
        '{16'h0207, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b1, 8'h00, 4'd8},  // R8 way1 still empty
        '{16'h0205, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hB2, 4'd3},  // R3 other offset hits
        '{16'h0304, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd9},  // R9 oldest is way0
        '{16'h0304, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd7},  // R7 plain miss changed nothing
        '{16'h0104, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1, 4'd5},  // R5 hit way0 data
        '{16'h0304, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b1, 8'h00, 4'd9},  // R9 restamp moved victim to way1
        '{16'h0204, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd6},  // R6 displaced line misses
        '{16'h0304, 1'b1, 8'hDD, 1'b1, 1'b1, 1'b0, 8'hC3, 4'd10}, // R10 fill on hit
        '{16'h0304, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hC3, 4'd10}, // R10 word unchanged
        '{16'h0108, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 same tag, set2
        '{16'h0108, 1'b1, 8'h5E, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 fill set2
        '{16'h0104, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1, 4'd1},  // R1 set1 untouched
        '{16'h0108, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h5E, 4'd5},  // R5 set2 hit
        '{16'h010C, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 set3 empty
        '{16'h0100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 4'd1}   // R1 set0 empty
    };

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic req(input logic [15:0] a, input logic f, input logic [7:0] wd);
        req_valid = 1'b1; req_addr = a; req_fill = f; req_wdata = wd;
        @(negedge clk);
    endtask

    task automatic fa_req(input logic [15:0] a, input logic f, input logic [7:0] wd);
        fa_valid = 1'b1; fa_addr = a; fa_fill = f; fa_wdata = wd;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset outputs", {rsp_valid, rsp_hit, rsp_data}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 idle no response", {63'd0, rsp_valid}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            req(VECS[i].addr, VECS[i].fill, VECS[i].wd);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i),
                  {rsp_valid, rsp_hit, rsp_way, rsp_victim, rsp_data},
                  {1'b1, VECS[i].hit, VECS[i].way, VECS[i].vic, VECS[i].data});
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R4 response drops after idle", {63'd0, rsp_valid}, 64'd0);

        // R2: a line filled before reset is gone afterwards.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        req(16'h0104, 1'b0, 8'h00);
        check("R2 lookup after reset", {rsp_valid, rsp_hit, rsp_way, rsp_victim, rsp_data},
              {1'b1, 1'b0, 1'b0, 1'b0, 8'h00});
        req_valid = 1'b0;

        // R11: one set, four ways, tag is addr[15:2].
        fa_req(16'h0000, 1'b1, 8'h11);
        check("R11 fill way0", {fa_hit, fa_victim}, {1'b0, 2'd0});
        fa_req(16'h0010, 1'b1, 8'h22);
        check("R11 fill way1", {fa_hit, fa_victim}, {1'b0, 2'd1});
        fa_req(16'h0020, 1'b1, 8'h33);
        check("R11 fill way2", {fa_hit, fa_victim}, {1'b0, 2'd2});
        fa_req(16'h0030, 1'b1, 8'h44);
        check("R11 fill way3", {fa_hit, fa_victim}, {1'b0, 2'd3});
        fa_req(16'h0000, 1'b0, 8'h00);
        check("R11 hit way0", {fa_rvalid, fa_hit, fa_way, fa_victim, fa_data},
              {1'b1, 1'b1, 2'd0, 2'd0, 8'h11});
        fa_req(16'h0040, 1'b1, 8'h55);
        check("R11 R9 evict oldest way1", {fa_hit, fa_victim}, {1'b0, 2'd1});
        fa_req(16'h0010, 1'b0, 8'h00);
        check("R11 evicted misses", {fa_hit, fa_victim}, {1'b0, 2'd2});
        fa_req(16'h0043, 1'b0, 8'h00);
        check("R11 new line hits", {fa_hit, fa_way, fa_data}, {1'b1, 2'd1, 8'h55});
        fa_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule